// File: doc/BRIEF.md
# Unidirectional Ring Bus Station

This block is one node of a unidirectional ring that carries snooping coherence messages. Each station links only to the station before it and the station after it. Every station registers the slot it sends downstream, so a message moves forward exactly one station per clock. The last station feeds the first.

In each cycle the station looks at the slot arriving from upstream. A message from another node is forwarded unchanged, and it is also copied to the local snoop port one cycle later. A message that this node sent earlier has now gone round the whole ring, so the station removes it, and that slot counts as empty. When the slot is empty, a local request offered on the ready/valid inject port goes into it, stamped with this node's id. Because every hop costs one cycle, each node sees messages injected in the same cycle in an order that depends on its distance from each sender.

Top module: `ring_station`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ring_out_valid` and `snoop_valid` are low. With no message arriving, `inj_ready` is high.
- R2: When `inj_valid` and `inj_ready` are both high at a clock edge, the next cycle shows `ring_out_valid` high, with `ring_out_src` equal to NODE_ID and the kind and address of the request.
- R3: A valid arriving message whose source differs from NODE_ID appears on `ring_out` one cycle later, with all fields unchanged. It takes priority over the local request: `inj_ready` is low in that cycle, and the waiting request is not placed on the ring.
- R4: A valid arriving message whose source equals NODE_ID is removed. Without a local request, `ring_out_valid` is low in the next cycle. `inj_ready` is high in that cycle, so a local request can use the freed slot at once.
- R5: Every arriving message from another node shows on `snoop_valid`/`snoop_src`/`snoop_kind`/`snoop_addr` one cycle after it arrives, with its fields unchanged. The station never snoops its own message. `snoop_valid` is low in any cycle that follows no such arrival.
- R6: In a ring of NODES stations with station i feeding station (i+1) mod NODES, a message injected by node s at edge E shows on the snoop port of node (s+d) mod NODES at edge E+d, for d = 1..NODES-1. It is gone from the ring after edge E+NODES. As a result, two nodes that inject in the same cycle are seen in opposite orders by different observers.
- R7: The kind field has 2 bits: 00 read-shared, 01 write-invalidate, 10 response, 11 reserved. Every code, including 11, travels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in_valid | input | 1 | Slot from upstream holds a message |
| ring_in_src | input | ID_W | Source node of upstream message |
| ring_in_kind | input | 2 | Kind of upstream message |
| ring_in_addr | input | ADDR_W | Line address of upstream message |
| ring_out_valid | output | 1 | Slot to downstream holds a message |
| ring_out_src | output | ID_W | Source node of outgoing message |
| ring_out_kind | output | 2 | Kind of outgoing message |
| ring_out_addr | output | ADDR_W | Line address of outgoing message |
| inj_valid | input | 1 | Local request to insert a message |
| inj_kind | input | 2 | Kind of local message |
| inj_addr | input | ADDR_W | Line address of local message |
| inj_ready | output | 1 | Local request is accepted this cycle |
| snoop_valid | output | 1 | Snoop copy of a foreign message |
| snoop_src | output | ID_W | Source of snooped message |
| snoop_kind | output | 2 | Kind of snooped message |
| snoop_addr | output | ADDR_W | Line address of snooped message |

## Verification
The bench joins four stations into a ring. Every source node injects every kind code on its own, and then every pair of sources injects in the same cycle. The expected arrival cycle at each observer comes from the ring distance. An extra hop, or a missing one, would put snoop copies in the wrong cycle or at the wrong node. A station that failed to remove its own message would leave the message circling forever, and a station that snooped its own message would raise a spurious snoop at the sender.

A saturation case fills all four slots in one cycle while a further local request waits. This exposes a design that lets the local request overwrite a passing message, one that raises ready too early, and one that fails to reuse the slot in the same cycle its own message is removed.

// File: rtl/ring_station.sv
module ring_station #(
  parameter int NODES   = 4,
  parameter int NODE_ID = 0,
  parameter int ADDR_W  = 16,
  localparam int ID_W   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_in_valid,
  input  logic [ID_W-1:0]   ring_in_src,
  input  logic [1:0]        ring_in_kind,
  input  logic [ADDR_W-1:0] ring_in_addr,
  output logic              ring_out_valid,
  output logic [ID_W-1:0]   ring_out_src,
  output logic [1:0]        ring_out_kind,
  output logic [ADDR_W-1:0] ring_out_addr,
  input  logic              inj_valid,
  input  logic [1:0]        inj_kind,
  input  logic [ADDR_W-1:0] inj_addr,
  output logic              inj_ready,
  output logic              snoop_valid,
  output logic [ID_W-1:0]   snoop_src,
  output logic [1:0]        snoop_kind,
  output logic [ADDR_W-1:0] snoop_addr
);

  localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

  logic own_back;
  logic passing;

  assign own_back  = ring_in_valid && (ring_in_src == MY_ID);
  assign passing   = ring_in_valid && !own_back;
  assign inj_ready = !passing;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_out_valid <= 1'b0;
      ring_out_src   <= '0;
      ring_out_kind  <= '0;
      ring_out_addr  <= '0;
    end else if (passing) begin
      ring_out_valid <= 1'b1;
      ring_out_src   <= ring_in_src;
      ring_out_kind  <= ring_in_kind;
      ring_out_addr  <= ring_in_addr;
    end else begin
      ring_out_valid <= inj_valid;
      ring_out_src   <= MY_ID;
      ring_out_kind  <= inj_kind;
      ring_out_addr  <= inj_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snoop_valid <= 1'b0;
      snoop_src   <= '0;
      snoop_kind  <= '0;
      snoop_addr  <= '0;
    end else begin
      snoop_valid <= passing;
      if (passing) begin
        snoop_src  <= ring_in_src;
        snoop_kind <= ring_in_kind;
        snoop_addr <= ring_in_addr;
      end
    end
  end

  assert_inject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && inj_ready |=> ring_out_valid && ring_out_src == MY_ID &&
      ring_out_kind == $past(inj_kind) && ring_out_addr == $past(inj_addr));

  assert_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ring_in_valid && ring_in_src != MY_ID |=> ring_out_valid &&
      ring_out_src == $past(ring_in_src) && ring_out_kind == $past(ring_in_kind) &&
      ring_out_addr == $past(ring_in_addr));

  assert_remove_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ring_in_valid && ring_in_src == MY_ID && !inj_valid |=> !ring_out_valid);

  assert_snoop_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ring_in_valid && ring_in_src != MY_ID |=> snoop_valid &&
      snoop_src == $past(ring_in_src) && snoop_kind == $past(ring_in_kind) &&
      snoop_addr == $past(ring_in_addr));

  assert_snoop_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ring_in_valid && ring_in_src != MY_ID) |=> !snoop_valid);

endmodule

// File: tb/ring_station_tb.sv
`timescale 1ns/1ps
module ring_station_tb;
  localparam int N  = 4;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          rv [N];
  logic [1:0]    rs [N];
  logic [1:0]    rk [N];
  logic [AW-1:0] ra [N];
  logic          iv [N];
  logic [1:0]    ik [N];
  logic [AW-1:0] ia [N];
  logic          ir [N];
  logic          sv [N];
  logic [1:0]    ss [N];
  logic [1:0]    sk [N];
  logic [AW-1:0] sa [N];

  for (genvar g = 0; g < N; g++) begin : g_node
    ring_station #(.NODES(N), .NODE_ID(g), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .ring_in_valid(rv[(g+N-1)%N]), .ring_in_src(rs[(g+N-1)%N]),
      .ring_in_kind(rk[(g+N-1)%N]), .ring_in_addr(ra[(g+N-1)%N]),
      .ring_out_valid(rv[g]), .ring_out_src(rs[g]),
      .ring_out_kind(rk[g]), .ring_out_addr(ra[g]),
      .inj_valid(iv[g]), .inj_kind(ik[g]), .inj_addr(ia[g]), .inj_ready(ir[g]),
      .snoop_valid(sv[g]), .snoop_src(ss[g]), .snoop_kind(sk[g]), .snoop_addr(sa[g])
    );
  end

  int tot = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tot++;
      bad++;
      $display("FAIL R6 watchdog act=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < N; n++) begin
      iv[n] = 1'b0; ik[n] = '0; ia[n] = '0;
    end
    repeat (3) step();
    for (int n = 0; n < N; n++) begin
      chk(!rv[n], "R1", "out_valid in reset", int'(rv[n]), 0);
      chk(!sv[n], "R1", "snoop_valid in reset", int'(sv[n]), 0);
    end
    rst_n = 1'b1;
    step();
    for (int n = 0; n < N; n++) begin
      chk(!rv[n] && !sv[n], "R1", "idle after reset", int'(rv[n]) + int'(sv[n]), 0);
      chk(ir[n], "R1", "ready when idle", int'(ir[n]), 1);
    end

    // single injections: every source, every kind code
    for (int s = 0; s < N; s++) begin
      for (int kd = 0; kd < 4; kd++) begin
        logic [AW-1:0] a;
        a = AW'(s * 16 + kd * 3 + 1);
        iv[s] = 1'b1; ik[s] = 2'(kd); ia[s] = a;
        chk(ir[s], "R2", "ready on empty slot", int'(ir[s]), 1);
        step();
        iv[s] = 1'b0;
        chk(rv[s] && rs[s] == 2'(s) && rk[s] == 2'(kd) && ra[s] == a,
            "R2", "injected slot addr", int'(ra[s]), int'(a));
        for (int k = 1; k <= N; k++) begin
          step();
          for (int n = 0; n < N; n++) begin
            bit e;
            e = (k < N) && (n == (s + k) % N);
            chk(sv[n] == e, (k == N) ? "R4" : "R6", "snoop_valid hop", int'(sv[n]), int'(e));
            chk(rv[n] == e, (k == N) ? "R4" : "R6", "out_valid hop", int'(rv[n]), int'(e));
            if (e) begin
              chk(ss[n] == 2'(s) && sa[n] == a, "R5", "snoop fields", int'(sa[n]), int'(a));
              chk(sk[n] == 2'(kd), "R7", "kind carried", int'(sk[n]), kd);
            end
          end
        end
      end
    end

    // every pair injecting in the same cycle
    for (int s1 = 0; s1 < N; s1++) begin
      for (int s2 = s1 + 1; s2 < N; s2++) begin
        iv[s1] = 1'b1; ik[s1] = 2'd1; ia[s1] = AW'(8'h80 + s1);
        iv[s2] = 1'b1; ik[s2] = 2'd0; ia[s2] = AW'(8'h80 + s2);
        step();
        iv[s1] = 1'b0; iv[s2] = 1'b0;
        for (int k = 1; k <= N; k++) begin
          step();
          for (int n = 0; n < N; n++) begin
            int src;
            bit e;
            src = (n - k + N) % N;
            e = (k < N) && (src == s1 || src == s2);
            chk(sv[n] == e, "R6", "order snoop_valid", int'(sv[n]), int'(e));
            if (e)
              chk(sa[n] == AW'(8'h80 + src) && ss[n] == 2'(src), "R6", "order snoop addr",
                  int'(sa[n]), 8'h80 + src);
          end
        end
      end
    end

    // saturated ring: node 1 must wait for its own slot to come back
    for (int n = 0; n < N; n++) begin
      iv[n] = 1'b1; ik[n] = 2'd2; ia[n] = AW'(8'h40 + n);
    end
    step();
    for (int n = 0; n < N; n++) iv[n] = 1'b0;
    iv[1] = 1'b1; ik[1] = 2'd3; ia[1] = 8'hEE;
    for (int k = 0; k < N - 1; k++) begin
      chk(!ir[1], "R3", "ready low while passing", int'(ir[1]), 0);
      step();
      chk(rv[1] && ra[1] == AW'(8'h40 + (1 - (k + 1) + N) % N), "R3", "passing kept over inject",
          int'(ra[1]), 8'h40 + (1 - (k + 1) + N) % N);
    end
    chk(ir[1], "R4", "ready when own slot returns", int'(ir[1]), 1);
    step();
    iv[1] = 1'b0;
    chk(rv[1] && ra[1] == 8'hEE && rs[1] == 2'd1 && rk[1] == 2'd3, "R4", "reuse freed slot",
        int'(ra[1]), 8'hEE);
    chk(!rv[0] && !rv[2] && !rv[3], "R4", "others removed", int'(rv[0]) + int'(rv[2]) + int'(rv[3]), 0);
    step();
    chk(sv[2] && sa[2] == 8'hEE && sk[2] == 2'd3, "R5", "snoop of late inject", int'(sa[2]), 8'hEE);
    repeat (N) step();
    for (int n = 0; n < N; n++)
      chk(!rv[n] && !sv[n], "R4", "ring drained", int'(rv[n]) + int'(sv[n]), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule